// File: doc/BRIEF.md
# Address-Match Debug Breakpoint Unit

This unit watches the CPU address bus and asks the core to enter background debug mode when a programmed 16-bit address is touched. Software loads the match address and two control bits through a small write port. An enable bit gates every request. A mode bit selects one of two kinds of breakpoint.

In forced mode, any valid bus access to the match address arms a pending request. The halt is issued at the next instruction boundary the core signals. In tagged mode, only an opcode fetch from the match address is marked: the unit raises a tag bit in the same cycle as the fetch. The pipeline carries that bit with the opcode and returns it on the execute strobe. The halt fires only if the tagged instruction actually reaches execution, so an instruction that is flushed never halts the core. The halt request is a one-cycle pulse.

Top module: `addrBreakpoint`

## Requirements
- R1: After reset, the enable and mode bits are 0, `haltReq` is 0 and `fetchTag` is 0.
- R2: While the enable bit is 0, `haltReq` and `fetchTag` stay 0 whatever the accesses, boundaries, execute tags, mode bit and match value.
- R3: A write with `cfgWrSel`=0 loads `cfgWrData` into the match register. A write with `cfgWrSel`=1 loads bit 0 as enable and bit 1 as mode (1 = forced, 0 = tagged). Both take effect from the cycle after the write.
- R4: In forced mode, a cycle with `busValid`=1 and `busAddr` equal to the match value sets a pending request, whether the access is a read, a write or a fetch. A later cycle with `instrBoundary`=1 makes `haltReq` 1 in the next cycle. A boundary in the same cycle as the access does not count.
- R5: In forced mode, one matching access produces exactly one `haltReq` pulse. Further boundaries without a new match produce none.
- R6: The compare covers all 16 address bits, so an address that differs in any single bit never matches.
- R7: In tagged mode, `fetchTag` is 1 in the same cycle as `busValid`=1, `busFetch`=1 and a matching address. A matching access with `busFetch`=0 gives `fetchTag`=0.
- R8: In tagged mode, a cycle with `execValid`=1 and `execTag`=1 makes `haltReq` 1 in the next cycle.
- R9: In tagged mode, instruction boundaries never halt, and a tag returned with `execValid`=0 (a flushed instruction) never halts. In forced mode, `execTag` has no effect.
- R10: Clearing the enable bit discards a pending forced request. Re-enabling the unit and then signalling a boundary gives no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 1 | 0 selects the match register, 1 selects the control bits |
| cfgWrData | input | 16 | Write data |
| busAddr | input | 16 | CPU address bus |
| busValid | input | 1 | An access is on the bus this cycle |
| busFetch | input | 1 | The access is an opcode fetch |
| instrBoundary | input | 1 | The core is at an instruction boundary |
| execValid | input | 1 | An instruction is about to execute |
| execTag | input | 1 | Tag bit returned with the executing instruction |
| fetchTag | output | 1 | Tag for the opcode being fetched this cycle |
| haltReq | output | 1 | One-cycle request to enter debug mode |

## Verification
The bench puts a matching access in the same cycle as a boundary. A design that counted that boundary would halt one instruction too early. The bench also sends repeated boundaries after a single hit; a design that never cleared the pending flag would halt again and again. It probes addresses that differ in one low bit and in one high bit, to catch a comparator that checks only part of the address. For tagged mode, it returns a tag with `execValid` low to stand for a flush, and it toggles the enable bit while a forced request is pending. A design that halts on flushed instructions, or that keeps a stale request across a disable, shows up as an unexpected `haltReq` pulse.

// File: rtl/addrBkptPkg.sv
package addrBkptPkg;
  localparam int ADDR_W   = 16;
  localparam int EN_BIT   = 0;
  localparam int MODE_BIT = 1;

  typedef struct packed {
    logic loadMatch;
    logic loadCtrl;
  } cfgStrobes_t;
endpackage

// File: rtl/addrBkptDatapath.sv
module addrBkptDatapath
  import addrBkptPkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfgStrobes_t   cfgStb,
  input  logic [AW-1:0] wrData,
  input  logic [AW-1:0] busAddr,
  output logic          matchHit,
  output logic          enable,
  output logic          forced
);
  logic [AW-1:0] matchReg;
  logic [AW-1:0] bitEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchReg <= '0;
      enable   <= 1'b0;
      forced   <= 1'b0;
    end else begin
      if (cfgStb.loadMatch) matchReg <= wrData;
      if (cfgStb.loadCtrl) begin
        enable <= wrData[EN_BIT];
        forced <= wrData[MODE_BIT];
      end
    end
  end

  // Per-bit equality, then a wide AND: the full address is compared.
  for (genvar i = 0; i < AW; i++) begin : g_cmp
    assign bitEq[i] = ~(busAddr[i] ^ matchReg[i]);
  end
  assign matchHit = &bitEq;

  assert_match_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgStb.loadMatch |=> (matchReg == $past(wrData)));
  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgStb.loadCtrl |=> (enable == $past(wrData[EN_BIT])));
endmodule

// File: rtl/addrBkptControl.sv
module addrBkptControl
  import addrBkptPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgWrSel,
  output cfgStrobes_t cfgStb,
  input  logic        matchHit,
  input  logic        enable,
  input  logic        forced,
  input  logic        busValid,
  input  logic        busFetch,
  input  logic        instrBoundary,
  input  logic        execValid,
  input  logic        execTag,
  output logic        fetchTag,
  output logic        haltReq
);
  logic armedForced, armedTagged, accessHit;
  logic pendingQ, pendingD, haltD;

  always_comb begin
    cfgStb.loadMatch = cfgWrEn && !cfgWrSel;
    cfgStb.loadCtrl  = cfgWrEn &&  cfgWrSel;
  end

  assign armedForced = enable && forced;
  assign armedTagged = enable && !forced;
  assign accessHit   = busValid && matchHit;
  assign fetchTag    = armedTagged && accessHit && busFetch;

  always_comb begin
    if (!armedForced)                 pendingD = 1'b0;
    else if (pendingQ && instrBoundary) pendingD = accessHit;
    else                              pendingD = pendingQ || accessHit;
    haltD = (armedForced && pendingQ && instrBoundary)
         || (armedTagged && execValid && execTag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      haltReq  <= 1'b0;
    end else begin
      pendingQ <= pendingD;
      haltReq  <= haltD;
    end
  end

  assert_halt_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> $past(enable));
  assert_forced_fire_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && forced && pendingQ && instrBoundary) |=> haltReq);
  assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && instrBoundary && !accessHit) |=> !pendingQ);
  assert_tag_fetch_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    fetchTag |-> (busValid && busFetch));
  assert_tag_fire_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !forced && execValid && execTag) |=> haltReq);
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pendingQ);
endmodule

// File: rtl/addrBreakpoint.sv
module addrBreakpoint
  import addrBkptPkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgWrSel,
  input  logic [AW-1:0] cfgWrData,
  input  logic [AW-1:0] busAddr,
  input  logic          busValid,
  input  logic          busFetch,
  input  logic          instrBoundary,
  input  logic          execValid,
  input  logic          execTag,
  output logic          fetchTag,
  output logic          haltReq
);
  cfgStrobes_t cfgStb;
  logic matchHit, enable, forced;

  addrBkptDatapath #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgStb(cfgStb), .wrData(cfgWrData),
    .busAddr(busAddr), .matchHit(matchHit), .enable(enable), .forced(forced)
  );

  addrBkptControl u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgStb(cfgStb), .matchHit(matchHit), .enable(enable), .forced(forced),
    .busValid(busValid), .busFetch(busFetch), .instrBoundary(instrBoundary),
    .execValid(execValid), .execTag(execTag), .fetchTag(fetchTag),
    .haltReq(haltReq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!haltReq && !fetchTag));
endmodule

// File: tb/addrBreakpoint_tb.sv
module addrBreakpoint_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgWrSel = 0;
  logic [15:0] cfgWrData = '0, busAddr = '0;
  logic busValid = 0, busFetch = 0, instrBoundary = 0, execValid = 0, execTag = 0;
  logic fetchTag, haltReq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  addrBreakpoint u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .busAddr(busAddr), .busValid(busValid),
    .busFetch(busFetch), .instrBoundary(instrBoundary), .execValid(execValid),
    .execTag(execTag), .fetchTag(fetchTag), .haltReq(haltReq)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    busValid = 0; busFetch = 0; instrBoundary = 0; execValid = 0; execTag = 0;
  endtask

  task automatic cfgWrite(logic sel, logic [15:0] data);
    cfgWrEn = 1; cfgWrSel = sel; cfgWrData = data;
    step();
    cfgWrEn = 0;
  endtask

  // One bus access; haltReq is checked after the edge that follows it.
  task automatic access(logic [15:0] a, logic f, logic bnd);
    busValid = 1; busAddr = a; busFetch = f; instrBoundary = bnd;
    step();
    idle();
  endtask

  task automatic boundary(string req, logic expHalt);
    instrBoundary = 1;
    step();
    idle();
    chk(req, haltReq, expHalt);
  endtask

  task automatic testReset();
    chk("R1 haltReq", haltReq, 1'b0);
    chk("R1 fetchTag", fetchTag, 1'b0);
    busValid = 1; busFetch = 1; busAddr = 16'h0000; #1;
    chk("R1 disabled after reset", fetchTag, 1'b0);
    idle();
  endtask

  task automatic testDisabled();
    cfgWrite(0, 16'h1234);
    cfgWrite(1, 16'h0002);          // forced mode, enable=0
    access(16'h1234, 0, 0);
    chk("R2 access", haltReq, 1'b0);
    boundary("R2 boundary", 1'b0);
    cfgWrite(1, 16'h0000);          // tagged, enable=0
    busValid = 1; busFetch = 1; busAddr = 16'h1234; #1;
    chk("R2 no tag", fetchTag, 1'b0);
    step(); idle();
    execValid = 1; execTag = 1; step(); idle();
    chk("R2 exec tag", haltReq, 1'b0);
  endtask

  task automatic testForced();
    cfgWrite(1, 16'h0003);
    access(16'h1234, 0, 1);         // boundary in the access cycle
    chk("R4 same-cycle boundary", haltReq, 1'b0);
    boundary("R4 next boundary", 1'b1);
    chk("R5 pulse width", haltReq, 1'b1);
    step();
    chk("R5 pulse ends", haltReq, 1'b0);
    boundary("R5 second boundary", 1'b0);
    access(16'h1234, 1, 0);         // fetch also counts
    boundary("R4 fetch access", 1'b1);
    access(16'h1235, 0, 0);
    boundary("R6 low bit differs", 1'b0);
    access(16'h9234, 0, 0);
    boundary("R6 high bit differs", 1'b0);
    execValid = 1; execTag = 1; step(); idle();
    chk("R9 forced ignores execTag", haltReq, 1'b0);
  endtask

  task automatic testMatchLoad();
    cfgWrite(0, 16'hBEEF);
    access(16'h1234, 0, 0);
    boundary("R3 old match gone", 1'b0);
    access(16'hBEEF, 0, 0);
    boundary("R3 new match", 1'b1);
  endtask

  task automatic testDisableClears();
    access(16'hBEEF, 0, 0);
    cfgWrite(1, 16'h0002);
    cfgWrite(1, 16'h0003);
    boundary("R10 pending dropped", 1'b0);
  endtask

  task automatic testTagged();
    cfgWrite(1, 16'h0001);
    busValid = 1; busFetch = 1; busAddr = 16'hBEEF; #1;
    chk("R7 fetch tagged", fetchTag, 1'b1);
    busFetch = 0; #1;
    chk("R7 data access untagged", fetchTag, 1'b0);
    busFetch = 1; busAddr = 16'hBEEE; #1;
    chk("R6 tag compare", fetchTag, 1'b0);
    busAddr = 16'hBEEF; step(); idle();
    chk("R9 fetch itself no halt", haltReq, 1'b0);
    boundary("R9 tagged boundary", 1'b0);
    execValid = 0; execTag = 1; step(); idle();
    chk("R9 flushed tag", haltReq, 1'b0);
    execValid = 1; execTag = 0; step(); idle();
    chk("R8 untagged exec", haltReq, 1'b0);
    execValid = 1; execTag = 1; step(); idle();
    chk("R8 tagged exec", haltReq, 1'b1);
    step();
    chk("R8 pulse ends", haltReq, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1;
        step();
        testDisabled();
        testForced();
        testMatchLoad();
        testDisableClears();
        testTagged();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule